// File: doc/BRIEF.md
# Banked Configuration Index/Data Port

This block is the configuration-space front end of an I/O controller. Software reaches it through a pair of adjacent byte addresses. The pair sits at 0x2E/0x2F, or at 0x4E/0x4F when the strap input is high. A write to the lower address of the pair stores a register index. An access to the upper address then reads or writes the register that the index names.

A small set of global registers sits below index 0x30:
- a logical-device selector at 0x07;
- a fixed device signature at 0x20;
- a revision code at 0x27.

From 0x30 upward, the index space maps onto a register bank. The bank is chosen by the logical-device selector. Each implemented logical device owns an enable flag and a 16-bit I/O base address. The block drives both continuously, so downstream address decoders can place that device's own register window.

Two logical devices are built by default, with codes 0x07 and 0x0E. The list of codes is a parameter. Read data is combinational and is valid in the same cycle as the read strobe. Register updates take effect at the clock edge that ends a write strobe.

Top module: `cfgport_top`

## Requirements
- R1: Only the two addresses of the pair respond. The pair is base and base+1, with base 0x2E when `strap_alt` is 0 and 0x4E when it is 1. Any other address reads as 0x00, and writes to it change no state.
- R2: A write at base loads the 8-bit index register. A read at base returns the current index.
- R3: The index is not altered by data accesses at base+1. Repeated data reads or writes therefore keep hitting the same register.
- R4: Index 0x07 is a read/write 8-bit logical-device selector.
- R5: Index 0x20 reads as the `DEV_ID` parameter (default 0xE9) and index 0x27 reads as the `REV_ID` parameter (default 0x03). Writes to either index are ignored. Every other global index below 0x30 reads 0x00.
- R6: In the selected device's bank, bit 0 of index 0x30 is the enable flag and drives `ld_active[i]`. This index reads back as {7'b0, flag}, and the other written bits are discarded.
- R7: In the selected device's bank, indices 0x60 and 0x61 hold the high and low bytes of the base address. That address appears on `ld_base[16*i +: 16]`. Other bank indices read 0x00.
- R8: If the selector holds a code that no implemented device has, every index from 0x30 upward reads 0xFF, and bank writes change no output.
- R9: After reset the index, the selector, all enable flags and all base addresses are zero.
- R10: Device slot i has code `LD_CODES[8*i +: 8]` (slot 0 = 0x07, slot 1 = 0x0E by default). Writing one device's bank leaves every other device's flag and base unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_alt | input | 1 | Port pair select: 0 gives 0x2E/0x2F, 1 gives 0x4E/0x4F |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational, 0x00 when no read hits the pair |
| ld_active | output | NUM_LD | Enable flag per implemented logical device |
| ld_base | output | 16*NUM_LD | I/O base address per implemented logical device |

## Verification
The assertions assume two things:
- `strap_alt` is constant outside reset, because they decode the pair from its present value;
- a write strobe and a read strobe are never raised together, because otherwise a read of the signature could coincide with a write to the data port.

The stimulus changes the strap only while reset is held, and it issues each access on its own cycle with a single strobe. Sweeps cover every index value under an unimplemented selector and every bank index under an implemented one, once per strap setting.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam logic [7:0]  IDX_LDN     = 8'h07;
  localparam logic [7:0]  IDX_DEVID   = 8'h20;
  localparam logic [7:0]  IDX_REV     = 8'h27;
  localparam logic [7:0]  BANK_FIRST  = 8'h30;
  localparam logic [7:0]  IDX_ACT     = 8'h30;
  localparam logic [7:0]  IDX_BASE_HI = 8'h60;
  localparam logic [7:0]  IDX_BASE_LO = 8'h61;
  localparam logic [15:0] PORT_PRI    = 16'h002E;
  localparam logic [15:0] PORT_ALT    = 16'h004E;
  localparam logic [7:0]  NO_DEV_RD   = 8'hFF;

  typedef struct packed {
    logic wr_idx;
    logic wr_dat;
    logic rd_idx;
    logic rd_dat;
  } port_op_t;
endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode
  import cfgport_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              strap_alt,
  output port_op_t          op
);
  logic [ADDR_W-1:0] base;
  logic              at_idx;
  logic              at_dat;

  always_comb begin
    base   = strap_alt ? ADDR_W'(PORT_ALT) : ADDR_W'(PORT_PRI);
    at_idx = (addr == base);
    at_dat = (addr == base + ADDR_W'(1));
    op.wr_idx = wr & at_idx;
    op.wr_dat = wr & at_dat;
    op.rd_idx = rd & at_idx;
    op.rd_dat = rd & at_dat;
  end
endmodule

// File: rtl/cfgport_index_regs.sv
module cfgport_index_regs
  import cfgport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  port_op_t   op,
  input  logic [7:0] wdata,
  output logic [7:0] idx_q,
  output logic [7:0] ldn_q
);
  logic [7:0] idx_d;
  logic [7:0] ldn_d;
  logic       idx_en;
  logic       ldn_en;

  always_comb begin
    idx_en = op.wr_idx;
    ldn_en = op.wr_dat && (idx_q == IDX_LDN);
    idx_d  = wdata;
    ldn_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= 8'h00;
      ldn_q <= 8'h00;
    end else begin
      if (idx_en) idx_q <= idx_d;
      if (ldn_en) ldn_q <= ldn_d;
    end
  end
endmodule

// File: rtl/cfgport_ld_bank.sv
module cfgport_ld_bank
  import cfgport_pkg::*;
#(
  parameter logic [7:0] LD_CODE = 8'h07
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_dat,
  input  logic [7:0]  idx,
  input  logic [7:0]  ldn,
  input  logic [7:0]  wdata,
  output logic        sel,
  output logic [7:0]  bank_rd,
  output logic        active,
  output logic [15:0] base
);
  logic        act_en;
  logic        hi_en;
  logic        lo_en;
  logic        act_d;
  logic [15:0] base_d;

  always_comb begin
    sel    = (ldn == LD_CODE);
    act_en = wr_dat && sel && (idx == IDX_ACT);
    hi_en  = wr_dat && sel && (idx == IDX_BASE_HI);
    lo_en  = wr_dat && sel && (idx == IDX_BASE_LO);
    act_d  = wdata[0];
    base_d = base;
    if (hi_en) base_d[15:8] = wdata;
    if (lo_en) base_d[7:0]  = wdata;
    case (idx)
      IDX_ACT:     bank_rd = {7'b0, active};
      IDX_BASE_HI: bank_rd = base[15:8];
      IDX_BASE_LO: bank_rd = base[7:0];
      default:     bank_rd = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= 16'h0000;
    end else begin
      if (act_en)         active <= act_d;
      if (hi_en || lo_en) base   <= base_d;
    end
  end
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter int                 ADDR_W   = 16,
  parameter int                 NUM_LD   = 2,
  parameter logic [NUM_LD*8-1:0] LD_CODES = {8'h0E, 8'h07},
  parameter logic [7:0]         DEV_ID   = 8'hE9,
  parameter logic [7:0]         REV_ID   = 8'h03
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strap_alt,
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic                 io_wr,
  input  logic                 io_rd,
  input  logic [7:0]           io_wdata,
  output logic [7:0]           io_rdata,
  output logic [NUM_LD-1:0]    ld_active,
  output logic [NUM_LD*16-1:0] ld_base
);
  localparam int BASE_W = 16;

  logic [1:0]  rst_pipe;
  logic        rst_sync_n;
  port_op_t    op;
  logic [7:0]  idx_q;
  logic [7:0]  ldn_q;
  logic [NUM_LD-1:0] bank_sel;
  logic [7:0]  bank_rd [NUM_LD];
  logic [7:0]  bank_or;
  logic        any_sel;
  logic [7:0]  glob_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cfgport_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(io_addr), .rd(io_rd), .wr(io_wr), .strap_alt(strap_alt), .op(op)
  );

  cfgport_index_regs u_idx (
    .clk(clk), .rst_n(rst_sync_n), .op(op), .wdata(io_wdata),
    .idx_q(idx_q), .ldn_q(ldn_q)
  );

  for (genvar i = 0; i < NUM_LD; i++) begin : g_ld
    cfgport_ld_bank #(.LD_CODE(LD_CODES[i*8 +: 8])) u_bank (
      .clk(clk), .rst_n(rst_sync_n), .wr_dat(op.wr_dat),
      .idx(idx_q), .ldn(ldn_q), .wdata(io_wdata),
      .sel(bank_sel[i]), .bank_rd(bank_rd[i]),
      .active(ld_active[i]), .base(ld_base[i*BASE_W +: BASE_W])
    );
  end

  always_comb begin
    bank_or = 8'h00;
    for (int i = 0; i < NUM_LD; i++) begin
      if (bank_sel[i]) bank_or = bank_or | bank_rd[i];
    end
    any_sel = |bank_sel;
    case (idx_q)
      IDX_LDN:   glob_rd = ldn_q;
      IDX_DEVID: glob_rd = DEV_ID;
      IDX_REV:   glob_rd = REV_ID;
      default:   glob_rd = 8'h00;
    endcase
    io_rdata = 8'h00;
    if (op.rd_idx) begin
      io_rdata = idx_q;
    end else if (op.rd_dat) begin
      if (idx_q < BANK_FIRST) io_rdata = glob_rd;
      else                    io_rdata = any_sel ? bank_or : NO_DEV_RD;
    end
  end
endmodule

// File: rtl/cfgport_checker.sv
module cfgport_checker #(
  parameter int                 ADDR_W   = 16,
  parameter int                 NUM_LD   = 2,
  parameter logic [NUM_LD*8-1:0] LD_CODES = {8'h0E, 8'h07},
  parameter logic [7:0]         DEV_ID   = 8'hE9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 strap_alt,
  input logic [ADDR_W-1:0]    io_addr,
  input logic                 io_wr,
  input logic                 io_rd,
  input logic [7:0]           io_wdata,
  input logic [7:0]           io_rdata,
  input logic [NUM_LD-1:0]    ld_active,
  input logic [NUM_LD*16-1:0] ld_base,
  input logic [7:0]           idx_q,
  input logic [7:0]           ldn_q
);
  logic [ADDR_W-1:0] pair_lo;
  logic at_idx, at_dat, known;

  always_comb begin
    pair_lo = strap_alt ? ADDR_W'(16'h004E) : ADDR_W'(16'h002E);
    at_idx  = (io_addr == pair_lo);
    at_dat  = (io_addr == pair_lo + ADDR_W'(1));
    known   = 1'b0;
    for (int i = 0; i < NUM_LD; i++) begin
      if (ldn_q == LD_CODES[i*8 +: 8]) known = 1'b1;
    end
  end

  p_nohit_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(at_idx || at_dat) |-> io_rdata == 8'h00);
  p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && at_idx) |=> idx_q == $past(io_wdata));
  p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && at_idx) |=> $stable(idx_q));
  p_devid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && at_dat && idx_q == 8'h20) |-> io_rdata == DEV_ID);
  p_act_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && at_dat) |=> $stable(ld_active));
  p_base_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && at_dat) |=> $stable(ld_base));
  p_unimpl_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && at_dat && idx_q >= 8'h30 && !known) |-> io_rdata == 8'hFF);
  p_unimpl_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && at_dat && !known) |=> ($stable(ld_active) && $stable(ld_base)));
  p_one_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && at_dat) |=> $countones(ld_active ^ $past(ld_active)) <= 1);
endmodule

bind cfgport_top cfgport_checker #(
  .ADDR_W(ADDR_W), .NUM_LD(NUM_LD), .LD_CODES(LD_CODES), .DEV_ID(DEV_ID)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .strap_alt(strap_alt), .io_addr(io_addr),
  .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
  .ld_active(ld_active), .ld_base(ld_base), .idx_q(idx_q), .ldn_q(ldn_q)
);

// File: tb/sim_cfgport_top.sv
module sim_cfgport_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        strap_alt;
  logic [15:0] io_addr;
  logic        io_wr;
  logic        io_rd;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic [1:0]  ld_active;
  logic [31:0] ld_base;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [7:0] EXP_ID  = 8'hE9;
  localparam logic [7:0] EXP_REV = 8'h03;

  always #2.5 clk = ~clk;

  cfgport_top u0 (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .ld_active(ld_active), .ld_base(ld_base)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_addr = 16'h0000;
  endtask

  task automatic do_rd(input logic [15:0] a, output logic [7:0] q);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 q = io_rdata;
    @(negedge clk);
    io_rd = 1'b0; io_addr = 16'h0000;
  endtask

  function automatic logic [7:0] glob_exp(input int i, input logic [7:0] ldn);
    if (i == 8'h07) return ldn;
    if (i == 8'h20) return EXP_ID;
    if (i == 8'h27) return EXP_REV;
    if (i < 8'h30) return 8'h00;
    return 8'hFF;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    logic [15:0] rb, wb;
    io_addr = 0; io_wr = 0; io_rd = 0; io_wdata = 0; strap_alt = 0; rst_n = 0;
    for (int s = 0; s < 2; s++) begin
      rst_n = 1'b0;
      strap_alt = s[0];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      rb = s[0] ? 16'h004E : 16'h002E;
      wb = s[0] ? 16'h002E : 16'h004E;

      // R9 reset state
      chk("R9 active", ld_active, 0);
      chk("R9 base", ld_base, 0);
      do_rd(rb, q); chk("R9 index", q, 0);
      do_wr(rb, 8'h07); do_rd(rb + 1, q); chk("R9 ldn", q, 0);

      // R1 other addresses
      do_wr(wb, 8'h20);
      do_rd(rb, q); chk("R1 wrong-base write ignored", q, 8'h07);
      do_rd(wb + 1, q); chk("R1 wrong-base read zero", q, 0);
      do_rd(rb + 2, q); chk("R1 adjacent read zero", q, 0);

      // R2 index load and read back
      do_wr(rb, 8'h5A); do_rd(rb, q); chk("R2 index readback", q, 8'h5A);

      // R4 R5 R8 sweep with selector 0 (unimplemented)
      for (int i = 0; i < 256; i++) begin
        do_wr(rb, 8'(i));
        do_rd(rb + 1, q);
        chk("R5 R8 global sweep", q, glob_exp(i, 8'h00));
      end

      // R5 writes to read-only ignored
      do_wr(rb, 8'h20); do_wr(rb + 1, 8'h00);
      do_rd(rb + 1, q); chk("R5 id write ignored", q, EXP_ID);
      do_wr(rb, 8'h27); do_wr(rb + 1, 8'hFF);
      do_rd(rb + 1, q); chk("R5 rev write ignored", q, EXP_REV);

      // R8 bank writes ignored when unimplemented
      do_wr(rb, 8'h30); do_wr(rb + 1, 8'h01);
      do_wr(rb, 8'h60); do_wr(rb + 1, 8'hAA);
      chk("R8 write ignored active", ld_active, 0);
      chk("R8 write ignored base", ld_base, 0);

      // R4 selector write, R3 repeated read
      do_wr(rb, 8'h07); do_wr(rb + 1, 8'h07);
      do_rd(rb + 1, q); chk("R4 ldn", q, 8'h07);
      do_rd(rb + 1, q); chk("R3 repeat read", q, 8'h07);

      // R6 R7 device 0x07 (slot 0)
      do_wr(rb, 8'h30); do_wr(rb + 1, 8'hFF);
      chk("R6 active slot0", ld_active, 2'b01);
      do_rd(rb + 1, q); chk("R6 act readback", q, 8'h01);
      do_wr(rb, 8'h60); do_wr(rb + 1, 8'h12);
      do_wr(rb, 8'h61); do_wr(rb + 1, 8'h34);
      chk("R7 base slot0", ld_base[15:0], 16'h1234);
      chk("R10 slot1 untouched", {ld_active[1], ld_base[31:16]}, 0);

      // R3 repeated writes hit same register
      do_wr(rb + 1, 8'h11); do_wr(rb + 1, 8'h22);
      chk("R3 repeat write", ld_base[15:0], 16'h1222);
      do_rd(rb, q); chk("R3 index kept", q, 8'h61);

      // R10 device 0x0E (slot 1)
      do_wr(rb, 8'h07); do_wr(rb + 1, 8'h0E);
      do_wr(rb, 8'h30); do_wr(rb + 1, 8'h03);
      do_wr(rb, 8'h60); do_wr(rb + 1, 8'hAB);
      do_wr(rb, 8'h61); do_wr(rb + 1, 8'hCD);
      chk("R10 slot1 base", ld_base[31:16], 16'hABCD);
      chk("R10 both active", ld_active, 2'b11);
      chk("R10 slot0 base kept", ld_base[15:0], 16'h1222);

      // R6 R7 bank sweep, device 0x0E
      for (int i = 8'h30; i < 256; i++) begin
        logic [7:0] e;
        e = (i == 8'h30) ? 8'h01 : (i == 8'h60) ? 8'hAB : (i == 8'h61) ? 8'hCD : 8'h00;
        do_wr(rb, 8'(i));
        do_rd(rb + 1, q);
        chk("R6 R7 bank sweep", q, e);
      end

      // R6 clear via bit 0 only
      do_wr(rb, 8'h07); do_wr(rb + 1, 8'h07);
      do_wr(rb, 8'h30); do_wr(rb + 1, 8'hFE);
      chk("R6 clear bit0", ld_active, 2'b10);

      // R8 unimplemented code reads FF, writes ignored
      do_wr(rb, 8'h07); do_wr(rb + 1, 8'h05);
      do_wr(rb, 8'h61); do_wr(rb + 1, 8'h99);
      do_rd(rb + 1, q); chk("R8 read FF", q, 8'hFF);
      chk("R8 base unchanged", ld_base, 32'hABCD_1222);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule